// File: doc/BRIEF.md
# Rectangle Fill Address Generator

This block sequences a solid rectangle fill for a 2-D drawing engine. A single `start` pulse presents a 16-bit command word, a starting corner and two extent counts. The generator then produces one output beat per pixel of the destination rectangle. Each beat carries the pixel's X and Y coordinates and a write-enable flag. Beats leave on a valid/ready stream. When the last beat has been taken, or when the command is not a rectangle fill, a one-cycle `done` pulse follows.

The scan runs row by row. X moves across the full row, then reloads to the starting column, and Y moves one line. Two command bits choose the direction on each axis, so the starting corner can be any corner of the rectangle. Coordinates wrap modulo 2^COORD_W. Two further command bits can suppress the pixel writes. In that case the beats are still emitted, with write-enable low, so that a downstream position tracker still sees the walk. Colour, raster mixing and memory access are handled elsewhere.

Top module: `rect_fill_gen`

## Requirements
- R1: After a synchronous active-low reset, including a reset that arrives mid-fill, `out_valid`, `done` and `busy` are all low.
- R2: A `start` taken while idle, with command bits [15:13] equal to 2, raises `busy` and `out_valid` on the next cycle, and the first beat carries (`dest_x`, `dest_y`).
- R3: Beats follow row-major order. X takes every value of a row before Y changes, and X returns to `dest_x` at the start of each new row.
- R4: The extents are inclusive. Counts W and H produce exactly (W+1)*(H+1) beats and no more.
- R5: Command bit 5 set makes X increase by one per step, and clear makes it decrease. Command bit 7 set makes Y increase by one per row, and clear makes it decrease. Both wrap modulo 2^COORD_W.
- R6: With command bit 4 clear, every beat is still emitted at its position, but with `out_we` low.
- R7: With command bit 0 clear, `out_we` is low on every beat. With bits 0 and 4 both set, `out_we` is high on every beat.
- R8: A `start` taken while idle with any other value in bits [15:13] produces `done` on the next cycle and no beats.
- R9: While `out_valid` is high and `out_ready` is low, the beat (`out_x`, `out_y`, `out_we`) holds unchanged in the next cycle.
- R10: `done` is high for exactly one cycle, in the cycle after the last beat is accepted. `busy` and `out_valid` are low in that cycle.
- R11: A `start` raised while `busy` is high is ignored, and the fill in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Command strobe, taken only while idle |
| cmd | input | CMD_W | Command word (opcode in [15:13], direction and write bits) |
| dest_x | input | COORD_W | Starting column |
| dest_y | input | COORD_W | Starting row |
| span_w | input | COORD_W | Horizontal count, inclusive |
| span_h | input | COORD_W | Vertical count, inclusive |
| busy | output | 1 | Fill in progress |
| out_valid | output | 1 | Beat present |
| out_ready | input | 1 | Consumer accepts beat |
| out_x | output | COORD_W | Beat column |
| out_y | output | COORD_W | Beat row |
| out_we | output | 1 | Beat writes the pixel |
| done | output | 1 | One-cycle completion or reject pulse |

## Verification
The bench builds the block with COORD_W set to 6, so coordinates live in a 64-pixel space. This places wrap-around in both directions, on each axis, within a few beats of an ordinary corner. It also makes a full-width row of 64 beats cheap enough to run as the widest-extent case. CMD_W keeps its default of 16, so the opcode field and the direction and write bits sit at their normal positions.

// File: rtl/rect_fill_pkg.sv
// Shared constants and types for the rectangle fill generator.
// Assumes a command word at least 16 bits wide.
package rect_fill_pkg;
    localparam int OP_LSB   = 13;
    localparam int OP_W     = 3;
    localparam logic [OP_W-1:0] OP_RECT = 3'd2;
    localparam int BIT_WR   = 0;
    localparam int BIT_DRAW = 4;
    localparam int BIT_XPOS = 5;
    localparam int BIT_YPOS = 7;

    typedef enum logic {ST_IDLE, ST_RUN} seq_state_t;

    typedef struct packed {
        logic is_rect;
        logic inc_x;
        logic inc_y;
        logic wr;
    } cmd_fields_t;
endpackage

// File: rtl/rf_cmd_decode.sv
// Command decoder: splits the command word into opcode match, the two
// direction flags and the combined pixel-write permission.
// Assumes CMD_W >= 16. Purely combinational.
module rf_cmd_decode #(
    parameter int CMD_W = 16
) (
    input  logic [CMD_W-1:0]            cmd,
    output rect_fill_pkg::cmd_fields_t  fields
);
    import rect_fill_pkg::*;

    logic unused_bits;

    // Field extraction.
    always_comb begin
        fields.is_rect = (cmd[OP_LSB +: OP_W] == OP_RECT);
        fields.inc_x   = cmd[BIT_XPOS];
        fields.inc_y   = cmd[BIT_YPOS];
        fields.wr      = cmd[BIT_DRAW] & cmd[BIT_WR];
    end

    assign unused_bits = ^cmd;
endmodule

// File: rtl/rf_axis.sv
// One scan axis: holds the current coordinate and a down-counter of the
// steps remaining. It captures the origin, extent and direction on load,
// can reload to the captured origin, and flags the last position.
// Assumes load, reload and step are never needed in the same cycle;
// load wins, then reload, then step.
module rf_axis #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] origin,
    input  logic [W-1:0] extent,
    input  logic         inc,
    input  logic         reload,
    input  logic         step,
    output logic [W-1:0] pos,
    output logic         at_end
);
    logic [W-1:0] base_q;
    logic [W-1:0] span_q;
    logic [W-1:0] rem_q;
    logic         inc_q;

    // Position and remaining-count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            span_q <= '0;
            rem_q  <= '0;
            pos    <= '0;
            inc_q  <= 1'b0;
        end else if (load) begin
            base_q <= origin;
            span_q <= extent;
            rem_q  <= extent;
            pos    <= origin;
            inc_q  <= inc;
        end else if (reload) begin
            pos    <= base_q;
            rem_q  <= span_q;
        end else if (step) begin
            pos    <= inc_q ? pos + 1'b1 : pos - 1'b1;
            rem_q  <= rem_q - 1'b1;
        end
    end

    assign at_end = (rem_q == '0);
endmodule

// File: rtl/rect_fill_gen.sv
// Rectangle fill address generator. Takes a command while idle. It rejects
// non-fill opcodes with a done pulse. For a fill it walks the rectangle
// row by row and emits one valid/ready beat per pixel, then pulses done.
// Assumes the consumer obeys valid/ready. Inputs other than start and
// out_ready are sampled only on the accepting cycle.
module rect_fill_gen #(
    parameter int COORD_W = 10,
    parameter int CMD_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [CMD_W-1:0]   cmd,
    input  logic [COORD_W-1:0] dest_x,
    input  logic [COORD_W-1:0] dest_y,
    input  logic [COORD_W-1:0] span_w,
    input  logic [COORD_W-1:0] span_h,
    output logic               busy,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [COORD_W-1:0] out_x,
    output logic [COORD_W-1:0] out_y,
    output logic               out_we,
    output logic               done
);
    import rect_fill_pkg::*;

    localparam int N_AXES = 2;

    seq_state_t  state_q;
    cmd_fields_t fld;
    logic        we_q;
    logic        done_q;
    logic        accept;
    logic        fire;
    logic        last_px;

    logic [N_AXES-1:0][COORD_W-1:0] ax_org;
    logic [N_AXES-1:0][COORD_W-1:0] ax_ext;
    logic [N_AXES-1:0][COORD_W-1:0] ax_pos;
    logic [N_AXES-1:0]              ax_inc;
    logic [N_AXES-1:0]              ax_rld;
    logic [N_AXES-1:0]              ax_stp;
    logic [N_AXES-1:0]              ax_end;

    rf_cmd_decode #(.CMD_W(CMD_W)) u_dec (
        .cmd    (cmd),
        .fields (fld)
    );

    // Handshake and start qualification.
    assign accept  = start && (state_q == ST_IDLE);
    assign fire    = (state_q == ST_RUN) && out_ready;
    assign last_px = ax_end[0] && ax_end[1];

    // Per-axis wiring: X steps every beat and reloads at the end of a
    // row; Y steps once per completed row and never reloads.
    assign ax_org = {dest_y, dest_x};
    assign ax_ext = {span_h, span_w};
    assign ax_inc = {fld.inc_y, fld.inc_x};
    assign ax_stp = {fire && ax_end[0] && !ax_end[1], fire && !ax_end[0]};
    assign ax_rld = {1'b0, fire && ax_end[0]};

    generate
        for (genvar a = 0; a < N_AXES; a++) begin : g_axis
            rf_axis #(.W(COORD_W)) u_axis (
                .clk    (clk),
                .rst_n  (rst_n),
                .load   (accept && fld.is_rect),
                .origin (ax_org[a]),
                .extent (ax_ext[a]),
                .inc    (ax_inc[a]),
                .reload (ax_rld[a]),
                .step   (ax_stp[a]),
                .pos    (ax_pos[a]),
                .at_end (ax_end[a])
            );
        end
    endgenerate

    // Sequencer state, latched write permission and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            we_q    <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (fld.is_rect) begin
                            state_q <= ST_RUN;
                            we_q    <= fld.wr;
                        end else begin
                            done_q  <= 1'b1;
                        end
                    end
                end
                ST_RUN: begin
                    if (fire && last_px) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state_q == ST_RUN);
    assign out_valid = (state_q == ST_RUN);
    assign out_x     = ax_pos[0];
    assign out_y     = ax_pos[1];
    assign out_we    = we_q;
    assign done      = done_q;
endmodule

// File: rtl/rect_fill_chk.sv
// Assertion checker for rect_fill_gen, attached by bind. It watches only
// the top-level ports.
module rect_fill_chk #(
    parameter int COORD_W = 10,
    parameter int CMD_W   = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [CMD_W-1:0]   cmd,
    input logic [COORD_W-1:0] dest_x,
    input logic [COORD_W-1:0] dest_y,
    input logic               busy,
    input logic               out_valid,
    input logic               out_ready,
    input logic [COORD_W-1:0] out_x,
    input logic [COORD_W-1:0] out_y,
    input logic               out_we,
    input logic               done
);
    import rect_fill_pkg::*;

    logic op_is_rect;
    assign op_is_rect = (cmd[OP_LSB +: OP_W] == OP_RECT);

    // R2: an accepted fill shows its starting corner on the next cycle.
    a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op_is_rect) |=>
            (out_valid && out_x == $past(dest_x) && out_y == $past(dest_y)));

    // R8: any other opcode is answered by done with no beat.
    a_r8_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !op_is_rect) |=> (done && !out_valid));

    // R9: a stalled beat holds.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_x) && $stable(out_y) && $stable(out_we)));

    // R10: done lasts one cycle and never overlaps a beat.
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!out_valid && !busy));

    // R11: a start during a fill neither ends nor drops it.
    a_r11_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !out_ready) |=> (busy && !done));
endmodule

bind rect_fill_gen rect_fill_chk #(.COORD_W(COORD_W), .CMD_W(CMD_W)) u_rect_fill_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cmd       (cmd),
    .dest_x    (dest_x),
    .dest_y    (dest_y),
    .busy      (busy),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_x     (out_x),
    .out_y     (out_y),
    .out_we    (out_we),
    .done      (done)
);

// File: tb/test_rect_fill_gen.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for the busy-start, reset and mid-fill reset cases.
module test_rect_fill_gen;
    localparam int CLK_PERIOD = 10;
    localparam int CW         = 6;
    localparam int NV         = 10;
    localparam int WATCHDOG   = 100000;

    typedef struct packed {
        logic [15:0]   cmd;
        logic [CW-1:0] dx;
        logic [CW-1:0] dy;
        logic [CW-1:0] w;
        logic [CW-1:0] h;
        logic [1:0]    rm;
    } vec_t;

    // Opcode in [15:13] (2 = fill), bit0 write, bit4 draw, bit5 +X, bit7 +Y.
    localparam vec_t VECS [NV] = '{
        '{16'h40B1, 6'd10, 6'd20, 6'd3,  6'd2, 2'd0},  // R3 R4 R5 positive
        '{16'h4011, 6'd5,  6'd5,  6'd2,  6'd3, 2'd1},  // R5 negative both
        '{16'h40A1, 6'd1,  6'd1,  6'd1,  6'd1, 2'd0},  // R6 bit4 clear
        '{16'h40B0, 6'd0,  6'd0,  6'd2,  6'd0, 2'd2},  // R7 bit0 clear
        '{16'h4031, 6'd62, 6'd1,  6'd3,  6'd1, 2'd1},  // R5 X wraps up
        '{16'h4091, 6'd0,  6'd63, 6'd0,  6'd2, 2'd0},  // R5 Y wraps up
        '{16'h40B1, 6'd0,  6'd0,  6'd0,  6'd0, 2'd2},  // R4 single pixel
        '{16'h20B1, 6'd3,  6'd3,  6'd1,  6'd1, 2'd0},  // R8 line opcode
        '{16'hE0B1, 6'd3,  6'd3,  6'd1,  6'd1, 2'd1},  // R8 opcode 7
        '{16'h40B1, 6'd0,  6'd0,  6'd63, 6'd0, 2'd1}   // R4 full width
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [15:0]   cmd = '0;
    logic [CW-1:0] dest_x = '0, dest_y = '0, span_w = '0, span_h = '0;
    logic          busy, out_valid, out_we, done;
    logic          out_ready = 1'b0;
    logic [CW-1:0] out_x, out_y;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    rect_fill_gen #(.COORD_W(CW), .CMD_W(16)) i_rect_fill_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd),
        .dest_x(dest_x), .dest_y(dest_y), .span_w(span_w), .span_h(span_h),
        .busy(busy), .out_valid(out_valid), .out_ready(out_ready),
        .out_x(out_x), .out_y(out_y), .out_we(out_we), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: act cycles %0d exp below %0d", cyc, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: act %0d exp %0d", req, act, exp);
        end
    endtask

    function automatic int beats_of(input vec_t v);
        if (v.cmd[15:13] != 3'd2) return 0;
        return (int'(v.w) + 1) * (int'(v.h) + 1);
    endfunction

    function automatic logic [CW-1:0] exp_x(input vec_t v, input int k);
        int col = k % (int'(v.w) + 1);
        return v.cmd[5] ? CW'(int'(v.dx) + col) : CW'(int'(v.dx) - col);
    endfunction

    function automatic logic [CW-1:0] exp_y(input vec_t v, input int k);
        int row = k / (int'(v.w) + 1);
        return v.cmd[7] ? CW'(int'(v.dy) + row) : CW'(int'(v.dy) - row);
    endfunction

    function automatic logic rdy_of(input logic [1:0] rm, input int c);
        if (rm == 2'd0) return 1'b1;
        if (rm == 2'd1) return c[0];
        return (c % 3) == 0;
    endfunction

    // Issue one command and follow it to done; poke raises start mid-fill.
    task automatic run_vec(input vec_t v, input bit poke);
        int   total = beats_of(v);
        int   k = 0;
        bit   fin = 0;
        logic pv = 0, pr = 0, pwe = 0;
        logic [CW-1:0] px = '0, py = '0;
        logic          r;
        @(negedge clk);
        start = 1'b1; cmd = v.cmd; dest_x = v.dx; dest_y = v.dy;
        span_w = v.w; span_h = v.h; out_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 3000; c++) begin
            if (poke && c == 2) begin start = 1'b1; cmd = 16'h0000; end
            if (poke && c == 3) start = 1'b0;
            if (pv && !pr)
                chk(out_valid && out_x == px && out_y == py && out_we == pwe,
                    "R9 stalled beat held", int'(out_x), int'(px));
            if (done) begin
                chk(k == total, "R4 R10 beats before done", k, total);
                chk(!busy && !out_valid, "R10 idle with done", int'(busy), 0);
                if (total == 0) chk(c == 0, "R8 reject done next cycle", c, 0);
                if (poke) chk(k == total, "R11 busy start ignored", k, total);
                fin = 1;
                break;
            end
            if (c == 0 && total > 0)
                chk(out_valid && busy, "R2 valid after start", int'(out_valid), 1);
            if (out_valid && k >= total) begin
                chk(0, "R4 extra beat", k + 1, total);
                break;
            end
            r = rdy_of(v.rm, c);
            out_ready = r;
            if (out_valid && r) begin
                chk(out_x == exp_x(v, k), "R3 R5 beat x", int'(out_x), int'(exp_x(v, k)));
                chk(out_y == exp_y(v, k), "R3 R5 beat y", int'(out_y), int'(exp_y(v, k)));
                chk(out_we == (v.cmd[4] & v.cmd[0]), "R6 R7 beat write",
                    int'(out_we), int'(v.cmd[4] & v.cmd[0]));
                k++;
            end
            pv = out_valid; pr = r; px = out_x; py = out_y; pwe = out_we;
            @(negedge clk);
        end
        if (!fin) chk(0, "R10 done seen", 0, 1);
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!out_valid && !done && !busy, "R1 reset state", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !done && !busy, "R1 idle after reset", int'(busy), 0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);

        // R11: a start while busy must leave the running fill intact.
        run_vec(VECS[0], 1'b1);

        // R1: a reset in the middle of a fill clears the outputs.
        @(negedge clk);
        start = 1'b1; cmd = 16'h40B1; dest_x = '0; dest_y = '0;
        span_w = 6'd63; span_h = 6'd0; out_ready = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        chk(out_valid, "R1 fill running before reset", int'(out_valid), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!out_valid && !busy && !done, "R1 mid-fill reset", int'(out_valid), 0);
        rst_n = 1'b1;
        out_ready = 1'b0;
        @(negedge clk);
        chk(!out_valid && !busy, "R1 stays idle", int'(busy), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule